// File: doc/BRIEF.md
# Slice-Addressable Register File

A bank of sixteen 64-bit registers with one combinational read port and one clocked write port. Each port picks a register with a 4-bit index and a part of that register with a 4-bit slice code. The slice can be a single byte, a 16-bit quarter, a 32-bit half or the whole word. A read returns the selected slice shifted down to bit 0, with zeros above it. A write replaces only the selected slice, and its data is taken from the low bits of the write data.

Indices 0 to 11 are general-purpose registers. Index 12 is the flags register, 13 the instruction register, 14 the program counter and 15 the stack register. The instruction register changes only through a separate full-word decoder port. The upper 32 bits of the flags register and of the program counter accept writes only while the privilege input is high. A write that is rejected this way raises a one-cycle violation strobe. A write with the unused slice code 15 is dropped and raises a one-cycle slice-error strobe.

Top module: `sreg_file`

## Requirements
- R1: The register index selects one of sixteen independent registers (0..11 general, 12 flags, 13 instruction, 14 program counter, 15 stack). A write to one register leaves every other register unchanged. Slice code 14 reads or writes all 64 bits.
- R2: Slice codes 0..7 select byte k, which covers bits 8k+7..8k.
- R3: Slice codes 8..11 select the 16-bit quarter q = code-8, covering bits 16q+15..16q. Code 12 selects bits 31..0 and code 13 selects bits 63..32.
- R4: A read returns the slice right-aligned and zero-extended. For example, a register holding 0xFEDCBA9876543210 reads 0xFEDCBA98 with code 13, 0x7654 with code 9, 0xBA with code 5 and 0x10 with code 0.
- R5: A write stores the low bits of the write data into the selected slice. Every bit outside that slice keeps its value.
- R6: A general-port write to index 13 is ignored. When the decoder write enable is high, index 13 loads the full decoder data on the next clock edge.
- R7: Without privilege, a write to index 12 or 14 whose slice covers any of bits 63..32 is dropped whole. The violation strobe is then high for exactly the following cycle. With privilege, the write is performed.
- R8: Slices wholly inside bits 31..0 of indices 12 and 14, and every slice of the other writable registers, can be written without privilege. These writes raise no violation strobe.
- R9: After reset, index 14 reads 0x0000000000001000 and index 15 reads 0xFFFFF000FFFFF000. All other registers read 0.
- R10: Slice code 15 is invalid. A read with it returns 0. A write with it changes nothing and raises the slice-error strobe for exactly the following cycle. The two strobes are never high together.
- R11: A write becomes visible on the read port right after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| priv_i | input | 1 | Privileged mode |
| rd_idx_i | input | 4 | Read register index |
| rd_sub_i | input | 4 | Read slice code |
| rd_data_o | output | 64 | Right-aligned, zero-extended read slice |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | Write register index |
| wr_sub_i | input | 4 | Write slice code |
| wr_data_i | input | 64 | Write data, low bits used |
| dec_we_i | input | 1 | Decoder write enable for the instruction register |
| dec_data_i | input | 64 | Decoder write data |
| bad_sub_o | output | 1 | One-cycle strobe after a write with slice code 15 |
| priv_viol_o | output | 1 | One-cycle strobe after a dropped privileged write |

## Verification
The hardest case to reach is the boundary between a guarded and an unguarded slice of the same register. The register must first be loaded with a distinctive value, because otherwise a dropped write and an accepted write can leave it looking the same. The stimulus therefore writes the program counter's low half without privilege, then tries its high half without privilege, and then writes the high half with privilege. After each step it reads back the whole word and samples the violation strobe in the cycle right after the attempt and again one cycle later. The flags register is tested with a byte in each half in the same way.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned NREGS  = 16;
  localparam int unsigned IDX_W  = $clog2(NREGS);
  localparam int unsigned SUB_W  = 4;
  localparam int unsigned NBYTES = XLEN / 8;
  localparam int unsigned SHW    = $clog2(XLEN);

  typedef logic [XLEN-1:0] word_t;

  localparam logic [IDX_W-1:0] IDX_FL = 4'd12;
  localparam logic [IDX_W-1:0] IDX_IN = 4'd13;
  localparam logic [IDX_W-1:0] IDX_PC = 4'd14;
  localparam logic [IDX_W-1:0] IDX_SP = 4'd15;

  localparam logic [NBYTES-1:0] UPPER_BYTES = {{(NBYTES/2){1'b1}}, {(NBYTES/2){1'b0}}};

  typedef struct packed {
    logic              valid;
    logic [NBYTES-1:0] bmask;
    logic [SHW-1:0]    shift;
  } slice_t;
endpackage

// File: rtl/sreg_slice_dec.sv
module sreg_slice_dec
  import sreg_pkg::*;
(
  input  logic [SUB_W-1:0] sub_i,
  output slice_t           sl_o
);
  always_comb begin
    sl_o = '0;
    sl_o.valid = 1'b1;
    if (sub_i < 4'd8) begin
      sl_o.bmask = NBYTES'(1) << sub_i[2:0];
      sl_o.shift = {sub_i[2:0], 3'b000};
    end else if (sub_i < 4'd12) begin
      sl_o.bmask = NBYTES'(3) << {sub_i[1:0], 1'b0};
      sl_o.shift = {sub_i[1:0], 4'b0000};
    end else if (sub_i < 4'd14) begin
      sl_o.bmask = NBYTES'(15) << {sub_i[0], 2'b00};
      sl_o.shift = {sub_i[0], 5'b00000};
    end else if (sub_i == 4'd14) begin
      sl_o.bmask = '1;
      sl_o.shift = '0;
    end else begin
      sl_o.valid = 1'b0;
    end
  end
endmodule

// File: rtl/sreg_byte_expand.sv
module sreg_byte_expand #(
  parameter int unsigned NB = 8
) (
  input  logic [NB-1:0]   bmask_i,
  output logic [NB*8-1:0] bits_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign bits_o[b*8 +: 8] = {8{bmask_i[b]}};
  end
endmodule

// File: rtl/sreg_access_gate.sv
module sreg_access_gate
  import sreg_pkg::*;
(
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  slice_t           sl_i,
  input  logic             priv_i,
  output logic             commit_o,
  output logic             bad_o,
  output logic             viol_o
);
  logic guarded, is_in, touch;

  assign guarded  = (idx_i == IDX_FL) || (idx_i == IDX_PC);
  assign is_in    = (idx_i == IDX_IN);
  assign touch    = guarded && |(sl_i.bmask & UPPER_BYTES);
  assign bad_o    = wr_en_i && !sl_i.valid;
  assign viol_o   = wr_en_i && sl_i.valid && touch && !priv_i;
  assign commit_o = wr_en_i && sl_i.valid && !is_in && !(touch && !priv_i);
endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_pkg::*;
#(
  parameter logic [63:0] RESET_PC = 64'h0000_0000_0000_1000,
  parameter logic [63:0] RESET_SP = 64'hFFFF_F000_FFFF_F000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             priv_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [SUB_W-1:0] rd_sub_i,
  output logic [XLEN-1:0]  rd_data_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [SUB_W-1:0] wr_sub_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic             dec_we_i,
  input  logic [XLEN-1:0]  dec_data_i,
  output logic             bad_sub_o,
  output logic             priv_viol_o
);
  word_t  regs_q [NREGS];
  slice_t rd_sl, wr_sl;
  word_t  rd_bits, wr_bits, wr_merge;
  logic   commit, bad_d, viol_d;

  sreg_slice_dec i_rd_dec (.sub_i(rd_sub_i), .sl_o(rd_sl));
  sreg_slice_dec i_wr_dec (.sub_i(wr_sub_i), .sl_o(wr_sl));

  sreg_byte_expand #(.NB(NBYTES)) i_rd_exp (.bmask_i(rd_sl.bmask), .bits_o(rd_bits));
  sreg_byte_expand #(.NB(NBYTES)) i_wr_exp (.bmask_i(wr_sl.bmask), .bits_o(wr_bits));

  sreg_access_gate i_gate (
    .wr_en_i (wr_en_i),
    .idx_i   (wr_idx_i),
    .sl_i    (wr_sl),
    .priv_i  (priv_i),
    .commit_o(commit),
    .bad_o   (bad_d),
    .viol_o  (viol_d)
  );

  function automatic word_t reset_val(int unsigned k);
    if (k == int'(IDX_PC)) return RESET_PC;
    if (k == int'(IDX_SP)) return RESET_SP;
    return '0;
  endfunction

  // invalid slice has empty mask, so the read collapses to zero
  assign rd_data_o = (regs_q[rd_idx_i] & rd_bits) >> rd_sl.shift;
  assign wr_merge  = (regs_q[wr_idx_i] & ~wr_bits) | ((wr_data_i << wr_sl.shift) & wr_bits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned k = 0; k < NREGS; k++) regs_q[k] <= reset_val(k);
      bad_sub_o   <= 1'b0;
      priv_viol_o <= 1'b0;
    end else begin
      for (int unsigned k = 0; k < NREGS; k++) begin
        if (k == int'(IDX_IN)) begin
          if (dec_we_i) regs_q[k] <= dec_data_i;
        end else if (commit && (wr_idx_i == IDX_W'(k))) begin
          regs_q[k] <= wr_merge;
        end
      end
      bad_sub_o   <= bad_d;
      priv_viol_o <= viol_d;
    end
  end
endmodule

// File: rtl/sreg_file_chk.sv
module sreg_file_chk
  import sreg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             priv_i,
  input logic [SUB_W-1:0] rd_sub_i,
  input logic [XLEN-1:0]  rd_data_o,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [SUB_W-1:0] wr_sub_i,
  input logic             dec_we_i,
  input logic [XLEN-1:0]  dec_data_i,
  input logic             bad_sub_o,
  input logic             priv_viol_o,
  input word_t            regs_q [NREGS]
);
  logic hi_touch, pc_guard_hit;

  always_comb begin
    case (wr_sub_i)
      4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11, 4'd13, 4'd14: hi_touch = 1'b1;
      default: hi_touch = 1'b0;
    endcase
  end
  assign pc_guard_hit = wr_en_i && !priv_i && (wr_idx_i == 4'd14) && hi_touch;

  AST_IN_GENERAL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == 4'd13 && !dec_we_i) |=> $stable(regs_q[13])); // R6
  AST_IN_DECODER_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_we_i |=> (regs_q[13] == $past(dec_data_i))); // R6
  AST_PC_SEG_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_guard_hit |=> $stable(regs_q[14])); // R7
  AST_VIOL_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_guard_hit |=> priv_viol_o); // R7
  AST_BAD_SUB_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sub_i == 4'd15) |=> bad_sub_o); // R10
  AST_BAD_SUB_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sub_i == 4'd15) |=> !bad_sub_o); // R10
  AST_RD_BAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sub_i == 4'd15) |-> (rd_data_o == '0)); // R10
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bad_sub_o, priv_viol_o})); // R10
  AST_BYTE0_KEEPS_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == 4'd0 && wr_sub_i == 4'd0) |=> (regs_q[0][63:8] == $past(regs_q[0][63:8]))); // R5
endmodule

bind sreg_file sreg_file_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .priv_i     (priv_i),
  .rd_sub_i   (rd_sub_i),
  .rd_data_o  (rd_data_o),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_sub_i   (wr_sub_i),
  .dec_we_i   (dec_we_i),
  .dec_data_i (dec_data_i),
  .bad_sub_o  (bad_sub_o),
  .priv_viol_o(priv_viol_o),
  .regs_q     (regs_q)
);

// File: tb/test_sreg_file.sv
`timescale 1ns/1ps
module test_sreg_file;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        priv_i = 1'b0;
  logic [3:0]  rd_idx_i = '0, rd_sub_i = '0;
  logic [63:0] rd_data_o;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0, wr_sub_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        dec_we_i = 1'b0;
  logic [63:0] dec_data_i = '0;
  logic        bad_sub_o, priv_viol_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sreg_file i_sreg_file (.*);

  typedef struct packed {
    logic        we;
    logic [3:0]  idx;
    logic [3:0]  sub;
    logic [63:0] wdata;
    logic [3:0]  rsub;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0,  4'd14, 64'hFEDCBA9876543210, 4'd14, 64'hFEDCBA9876543210, 8'd1},
    '{1'b0, 4'd0,  4'd0,  64'h0,                4'd13, 64'hFEDCBA98,         8'd4},
    '{1'b0, 4'd0,  4'd0,  64'h0,                4'd9,  64'h7654,             8'd4},
    '{1'b0, 4'd0,  4'd0,  64'h0,                4'd5,  64'hBA,               8'd4},
    '{1'b0, 4'd0,  4'd0,  64'h0,                4'd0,  64'h10,               8'd4},
    '{1'b0, 4'd0,  4'd0,  64'h0,                4'd12, 64'h76543210,         8'd3},
    '{1'b0, 4'd0,  4'd0,  64'h0,                4'd11, 64'hFEDC,             8'd3},
    '{1'b0, 4'd0,  4'd0,  64'h0,                4'd7,  64'hFE,               8'd2},
    '{1'b0, 4'd0,  4'd0,  64'h0,                4'd2,  64'h54,               8'd2},
    '{1'b1, 4'd0,  4'd3,  64'hAA,               4'd14, 64'hFEDCBA98AA543210, 8'd5},
    '{1'b1, 4'd0,  4'd10, 64'h12345678,         4'd14, 64'hFEDC5678AA543210, 8'd5},
    '{1'b1, 4'd0,  4'd13, 64'h0,                4'd14, 64'h00000000AA543210, 8'd5},
    '{1'b1, 4'd9,  4'd14, 64'h1111,             4'd14, 64'h1111,             8'd1},
    '{1'b0, 4'd10, 4'd0,  64'h0,                4'd14, 64'h0,                8'd1},
    '{1'b1, 4'd11, 4'd12, 64'hFFFFFFFFCAFEF00D, 4'd14, 64'h00000000CAFEF00D, 8'd5},
    '{1'b1, 4'd11, 4'd8,  64'hBEEF,             4'd14, 64'h00000000CAFEBEEF, 8'd3}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, input logic [3:0] sub, output logic [63:0] val);
    rd_idx_i = idx;
    rd_sub_i = sub;
    #1;
    val = rd_data_o;
  endtask

  // strobes sampled 1ns after the capturing edge
  task automatic wr(input logic [3:0] idx, input logic [3:0] sub, input logic [63:0] d, input logic p);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_sub_i = sub; wr_data_i = d; priv_i = p;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; priv_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    logic bs, pv;
    #12 rst_ni = 1'b1;

    // R9 reset state
    rd(4'd14, 4'd14, v); check("R9 pc", v, 64'h0000000000001000);
    rd(4'd15, 4'd14, v); check("R9 sp", v, 64'hFFFFF000FFFFF000);
    rd(4'd0, 4'd14, v);  check("R9 a", v, 64'h0);
    rd(4'd13, 4'd14, v); check("R9 in", v, 64'h0);
    check("R9 strobes", {62'h0, bad_sub_o, priv_viol_o}, 64'h0);

    // table walk: R1 R2 R3 R4 R5 R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_en_i = VECS[i].we; wr_idx_i = VECS[i].idx; wr_sub_i = VECS[i].sub;
      wr_data_i = VECS[i].wdata;
      rd_idx_i = VECS[i].idx; rd_sub_i = VECS[i].rsub;
      @(posedge clk_i);
      #1;
      wr_en_i = 1'b0;
      checks++;
      if (rd_data_o !== VECS[i].exp) begin
        errors++;
        $display("FAIL R%0d vec %0d: got %h expected %h", VECS[i].req, i, rd_data_o, VECS[i].exp);
      end
    end

    // R6 instruction register
    wr(4'd13, 4'd14, 64'h123, 1'b1);
    rd(4'd13, 4'd14, v); check("R6 general ignored", v, 64'h0);
    @(negedge clk_i); dec_we_i = 1'b1; dec_data_i = 64'hDEAD0000BEEF;
    @(posedge clk_i); #1; dec_we_i = 1'b0;
    rd(4'd13, 4'd14, v); check("R6 decoder load", v, 64'hDEAD0000BEEF);

    // R8 low half of pc without privilege
    wr(4'd14, 4'd12, 64'h2000, 1'b0);
    pv = priv_viol_o;
    rd(4'd14, 4'd14, v); check("R8 pc low", v, 64'h0000000000002000);
    check("R8 no viol", {63'h0, pv}, 64'h0);

    // R7 segment without privilege
    wr(4'd14, 4'd13, 64'h5, 1'b0);
    pv = priv_viol_o;
    rd(4'd14, 4'd14, v); check("R7 pc hi dropped", v, 64'h0000000000002000);
    check("R7 viol high", {63'h0, pv}, 64'h1);
    @(posedge clk_i); #1;
    check("R7 viol one cycle", {63'h0, priv_viol_o}, 64'h0);

    // R7 full word touches upper half
    wr(4'd14, 4'd14, 64'h0, 1'b0);
    pv = priv_viol_o;
    rd(4'd14, 4'd14, v); check("R7 pc word dropped", v, 64'h0000000000002000);
    check("R7 viol word", {63'h0, pv}, 64'h1);

    // R7 segment with privilege
    wr(4'd14, 4'd13, 64'h7, 1'b1);
    pv = priv_viol_o;
    rd(4'd14, 4'd14, v); check("R7 pc hi priv", v, 64'h0000000700002000);
    check("R7 no viol priv", {63'h0, pv}, 64'h0);

    // R7 / R8 flags bytes
    wr(4'd12, 4'd0, 64'h5, 1'b0);
    wr(4'd12, 4'd7, 64'h80, 1'b0);
    pv = priv_viol_o;
    rd(4'd12, 4'd14, v); check("R7 fl hi dropped", v, 64'h5);
    check("R7 fl viol", {63'h0, pv}, 64'h1);

    // R8 stack upper half unguarded
    wr(4'd15, 4'd13, 64'h1, 1'b0);
    pv = priv_viol_o;
    rd(4'd15, 4'd14, v); check("R8 sp hi", v, 64'h00000001FFFFF000);
    check("R8 sp no viol", {63'h0, pv}, 64'h0);

    // R10 invalid slice code
    wr(4'd0, 4'd15, 64'hFFFFFFFFFFFFFFFF, 1'b1);
    bs = bad_sub_o; pv = priv_viol_o;
    rd(4'd0, 4'd14, v); check("R10 write ignored", v, 64'h00000000AA543210);
    check("R10 bad strobe", {62'h0, bs, pv}, 64'h2);
    rd(4'd0, 4'd15, v); check("R10 read zero", v, 64'h0);
    @(posedge clk_i); #1;
    check("R10 strobe one cycle", {63'h0, bad_sub_o}, 64'h0);

    // R5 byte 0 write keeps rest
    wr(4'd0, 4'd0, 64'h3C, 1'b0);
    rd(4'd0, 4'd14, v); check("R5 byte0", v, 64'h00000000AA54323C);

    finish_run();
  end
endmodule